// File: doc/BRIEF.md
# Daisy-Chain Command Frame Transmitter

This block turns one command (a device address, a register address, a data byte and a broadcast flag) into a 32-bit word for a chain of battery-monitor devices. It then shifts that word out over a four-wire serial link. The word carries an 8-bit check code computed from the upper 21 bits and ends in a fixed three-bit tail. When the host only wants to clock responses back from the chain, it raises `rd_only`. The block then sends a fixed, valid filler word instead of the fields.

The serial clock comes from the system clock through a parameterized divider. `HALF_DIV` system clocks make one half-period of the serial clock. The host pulses `start` for one cycle while `busy` is low. `busy` stays high through the whole frame and through the idle time that follows it.

Top module: `cmdtx_chain_tx`

## Requirements
- R1: The transmitted word puts the device address in bits 31:27, the register address in bits 26:21, the data byte in bits 20:13 and the broadcast flag in bit 12. Bit 11 is 0.
- R2: Bits 10:3 hold the remainder of the 21-bit value in word bits 31:11, divided by the polynomial x^8+x^5+x^3+x^2+x+1. No zero bits are appended to that value before the division.
- R3: Bits 2:0 are always 3'b010, and they take no part in the check code.
- R4: With `rd_only` high at start, the word sent is 32'hF800030A, whatever the field inputs hold.
- R5: Each frame has exactly 32 serial clock cycles while `cs_n` is low. The most significant bit goes first.
- R6: The serial clock idles low whenever `cs_n` is high. `mosi` changes only on rising edges of `sclk` and is stable across every falling edge.
- R7: Every half-period of `sclk` lasts `HALF_DIV` system clocks. The first rising edge comes `HALF_DIV` clocks after `cs_n` falls, and `cs_n` stays low for 65×`HALF_DIV` clocks.
- R8: `busy` and a low `cs_n` appear on the clock edge that samples `start`. `busy` stays high for 66×`HALF_DIV` clocks, which includes one half-period with `cs_n` high after the frame.
- R9: A `start` pulse while `busy` is high is ignored. The frame in progress, its length and the next frame are all unaffected.
- R10: After reset, `cs_n`=1, `sclk`=0, `mosi`=0 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send a frame |
| rd_only | input | 1 | Send the fixed filler word instead of the fields |
| dev_addr | input | 5 | Target device address |
| reg_addr | input | 6 | Target register address |
| wr_data | input | 8 | Data byte to write |
| bcast | input | 1 | Write to all devices in the chain |
| busy | output | 1 | Frame or post-frame idle time in progress |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |

## Verification
`busy` and `cs_n` respond on the first clock edge after the start pulse, so the bench checks them at the next falling clock edge. From that point it counts falling clock edges: 65×`HALF_DIV` with `cs_n` low and 66×`HALF_DIV` with `busy` high. A monitor shifts in `mosi` on each falling edge of `sclk`. It also checks that rising edges are 2×`HALF_DIV` clocks apart. Once `busy` has dropped, the captured word is compared with one built by bench functions. The word is checked field by field: the fields, the check code and the tail separately.

// File: rtl/cmdtx_pkg.sv
package cmdtx_pkg;
    localparam int FRAME_W  = 32;
    localparam int DEV_W    = 5;
    localparam int REG_W    = 6;
    localparam int DATA_W   = 8;
    localparam int CRC_W    = 8;
    localparam int BODY_W   = FRAME_W - CRC_W - 3;   // 21 bits covered by the check code
    localparam int TAIL_W   = 3;
    localparam logic [CRC_W:0]     GEN_POLY  = 9'h12F;
    localparam logic [TAIL_W-1:0]  TAIL_BITS = 3'b010;
    localparam logic [FRAME_W-1:0] FILL_WORD = 32'hF800030A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } tx_state_e;
endpackage

// File: rtl/cmdtx_crc8.sv
module cmdtx_crc8
    import cmdtx_pkg::*;
(
    input  logic [BODY_W-1:0] body,
    output logic [CRC_W-1:0]  crc
);
    logic [BODY_W-1:0] rem;

    // Long division of the body by the generator, no augmentation.
    always_comb begin
        rem = body;
        for (int i = BODY_W - 1; i >= CRC_W; i--) begin
            if (rem[i]) begin
                rem = rem ^ (BODY_W'(GEN_POLY) << (i - CRC_W));
            end
        end
        crc = rem[CRC_W-1:0];
    end
endmodule

// File: rtl/cmdtx_frame.sv
module cmdtx_frame
    import cmdtx_pkg::*;
(
    input  logic               rd_only,
    input  logic [DEV_W-1:0]   dev_addr,
    input  logic [REG_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               bcast,
    output logic [FRAME_W-1:0] word
);
    logic [BODY_W-1:0] body;
    logic [CRC_W-1:0]  crc;

    assign body = {dev_addr, reg_addr, wr_data, bcast, 1'b0};

    cmdtx_crc8 u_crc (
        .body (body),
        .crc  (crc)
    );

    assign word = rd_only ? FILL_WORD : {body, crc, TAIL_BITS};
endmodule

// File: rtl/cmdtx_shifter.sv
module cmdtx_shifter
    import cmdtx_pkg::*;
#(
    parameter int HALF_DIV = 143
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] word,
    output logic               busy,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);
    localparam int CNT_W   = $clog2(HALF_DIV + 1);
    localparam int EDGES   = 2 * FRAME_W;
    localparam int TOG_W   = $clog2(EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HALF_DIV - 1);
    localparam logic [TOG_W-1:0] TOG_LAST = TOG_W'(EDGES - 1);

    typedef struct packed {
        tx_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [TOG_W-1:0]   tog;
        logic [FRAME_W-1:0] shreg;
        logic               sclk;
        logic               cs_n;
    } shift_regs_t;

    shift_regs_t st_d, st_q;
    logic        tick;

    assign tick = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (st_q.state != ST_IDLE) begin
            st_d.cnt = tick ? CNT_LOAD : st_q.cnt - 1'b1;
        end
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state = ST_LEAD;
                    st_d.cnt   = CNT_LOAD;
                    st_d.tog   = '0;
                    st_d.shreg = word;
                    st_d.cs_n  = 1'b0;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    st_d.sclk  = 1'b1;
                    st_d.tog   = TOG_W'(1);
                    st_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    st_d.sclk = ~st_q.sclk;
                    st_d.tog  = st_q.tog + 1'b1;
                    if (!st_q.sclk) begin
                        st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b0};
                    end
                    if (st_q.tog == TOG_LAST) begin
                        st_d.state = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    st_d.cs_n  = 1'b1;
                    st_d.state = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    st_d.state = ST_IDLE;
                    st_d.shreg = '0;
                    st_d.cnt   = '0;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.cnt   <= '0;
            st_q.tog   <= '0;
            st_q.shreg <= '0;
            st_q.sclk  <= 1'b0;
            st_q.cs_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.state != ST_IDLE);
    assign sclk = st_q.sclk;
    assign cs_n = st_q.cs_n;
    assign mosi = st_q.shreg[FRAME_W-1];
endmodule

// File: rtl/cmdtx_chain_tx.sv
module cmdtx_chain_tx
    import cmdtx_pkg::*;
#(
    parameter int HALF_DIV = 143
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_only,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bcast,
    output logic              busy,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi
);
    logic [FRAME_W-1:0] word;

    cmdtx_frame u_frame (
        .rd_only  (rd_only),
        .dev_addr (dev_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .bcast    (bcast),
        .word     (word)
    );

    cmdtx_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (word),
        .busy  (busy),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .mosi  (mosi)
    );
endmodule

// File: rtl/cmdtx_chain_tx_chk.sv
module cmdtx_chain_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic sclk,
    input logic cs_n,
    input logic mosi
);
    // R6
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $stable(mosi));

    // R8
    cs_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R8
    gap_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> busy);

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !cs_n));

    // R9
    start_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_n && start) |=> cs_n);
endmodule

bind cmdtx_chain_tx cmdtx_chain_tx_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi)
);

// File: tb/cmdtx_chain_tx_test.sv
`timescale 1ns/1ps
module cmdtx_chain_tx_test;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_only = 1'b0;
    logic [4:0] dev_addr = '0;
    logic [5:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic       bcast = 1'b0;
    logic       busy, sclk, cs_n, mosi;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    cmdtx_chain_tx #(.HALF_DIV(H)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_only(rd_only),
        .dev_addr(dev_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .bcast(bcast), .busy(busy), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
    );

    // Serial monitor
    logic [31:0] cap;
    int nbits = 0;
    int cyc = 0;
    int last_rise = -1;
    int bad_period = 0;

    always @(posedge clk) cyc++;
    always @(negedge cs_n) begin nbits = 0; last_rise = -1; end
    always @(negedge sclk) if (!cs_n) begin cap = {cap[30:0], mosi}; nbits++; end
    always @(posedge sclk) begin
        if (last_rise >= 0 && (cyc - last_rise) != 2 * H) bad_period++;
        last_rise = cyc;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [20:0] body);
        logic [7:0] r = 8'h00;
        for (int i = 20; i >= 0; i--) begin
            logic top = r[7];
            r = {r[6:0], body[i]};
            if (top) r = r ^ 8'h2F;
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_word(input logic rd, input logic [4:0] d,
        input logic [5:0] a, input logic [7:0] v, input logic b);
        logic [20:0] body = {d, a, v, b, 1'b0};
        if (rd) return 32'hF800030A;
        return {body, ref_crc(body), 3'b010};
    endfunction

    task automatic send(input logic rd, input logic [4:0] d, input logic [5:0] a,
        input logic [7:0] v, input logic b, input logic poke);
        logic [31:0] exp = ref_word(rd, d, a, v, b);
        int busy_cnt = 1;
        int cs_cnt = 1;
        int it = 0;
        @(negedge clk);
        rd_only = rd; dev_addr = d; reg_addr = a; wr_data = v; bcast = b; start = 1'b1;
        bad_period = 0;
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after start", {31'd0, busy}, 32'd1);
        check("R8 cs_n after start", {31'd0, cs_n}, 32'd0);
        while (busy) begin
            @(negedge clk);
            it++;
            start = 1'b0;
            if (poke && (it == 40 || it == 65 * H - 1)) begin
                // R9: stray starts mid-frame and during the gap, with other fields
                start = 1'b1; rd_only = ~rd; dev_addr = ~d; wr_data = ~v;
            end
            if (busy) busy_cnt++;
            if (!cs_n) cs_cnt++;
        end
        start = 1'b0;
        check("R7 cs_n low cycles", cs_cnt, 65 * H);
        check("R8 busy cycles", busy_cnt, 66 * H);
        check("R5 bit count", nbits, 32);
        check("R6 sclk idle low", {31'd0, sclk}, 32'd0);
        check("R7 sclk period", bad_period, 0);
        if (rd) begin
            check("R4 filler word", cap, exp);
        end else begin
            check("R1 fields", {11'd0, cap[31:11]}, {11'd0, exp[31:11]});
            check("R2 crc", {24'd0, cap[10:3]}, {24'd0, exp[10:3]});
            check("R3 tail", {29'd0, cap[2:0]}, 32'd2);
        end
        @(negedge clk);
        check("R9 no restart", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        check("R10 reset cs_n", {31'd0, cs_n}, 32'd1);
        check("R10 reset sclk", {31'd0, sclk}, 32'd0);
        check("R10 reset mosi", {31'd0, mosi}, 32'd0);
        check("R10 reset busy", {31'd0, busy}, 32'd0);

        send(1'b0, 5'h00, 6'h00, 8'h00, 1'b0, 1'b0);
        check("R2 zero crc", cap, 32'h00000002);
        send(1'b0, 5'h1F, 6'h3F, 8'hFF, 1'b1, 1'b0);
        send(1'b0, 5'h00, 6'h0D, 8'h30, 1'b1, 1'b0);
        send(1'b1, 5'h0A, 6'h15, 8'h5A, 1'b1, 1'b0);
        send(1'b0, 5'h03, 6'h1C, 8'hA4, 1'b0, 1'b1);
        send(1'b1, 5'h11, 6'h02, 8'h00, 1'b0, 1'b1);
        for (int k = 0; k < 12; k++) begin
            send(1'($urandom % 5 == 0), 5'($urandom), 6'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom % 3 == 0));
        end
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule